// File: doc/BRIEF.md
# Parity-Protected Two-Way Instruction Cache Tag Lookup

This block holds the tag store of a small two-way set-associative instruction cache and answers lookups against it. Each way of each set keeps a valid bit, a tag and one parity bit. The parity bit is even parity over the 31-bit granule made of the valid bit and a 30-bit tag. A lookup reads both ways of the addressed set in the cycle it is accepted. It checks parity on both entries and compares the tags. The response appears on the next cycle, so a clean lookup costs no more than an unprotected one.

When either entry of the addressed set fails its parity check, the block does not report a fault. It stalls for one cycle and clears both ways of that set. It then answers the lookup as a miss with a refetch flag, so that the line is fetched again from the next level. During the stall it emits an error event that carries the set index and the failing ways.

Single-bit parity cannot see two flipped bits within one granule. Such an entry is compared as stored, and the result is whatever that compare produces. A write port installs or removes tags. It has an error-injection input that stores the parity bit inverted, which lets the protection path be exercised.

Top module: `icache_tag_check`

## Requirements
- R1: After reset every entry is invalid and holds correct parity. Every lookup then returns a miss with refetch clear, and busy is low.
- R2: A lookup accepted in cycle t whose tag matches a valid, parity-clean entry gives, in cycle t+1, rsp_valid=1 and rsp_hit=1. rsp_way gives the matching way (0 or 1); way 0 is reported if both ways match.
- R3: A lookup accepted in cycle t with a clean set and no matching valid entry gives, in cycle t+1, rsp_valid=1, rsp_hit=0 and rsp_refetch=0.
- R4: With no parity error, lookups are accepted on every cycle (lk_ready=1) and each one gets exactly one response one cycle later.
- R5: A write stores parity equal to the XOR of wr_valid and wr_tag, inverted when wr_par_flip=1. An entry is in error when the XOR of its valid bit, tag and parity bit is 1. This holds whether the entry is valid or not.
- R6: A lookup accepted in cycle t that finds an error in either way drives busy=1 and lk_ready=0 in cycle t+1, with rsp_valid=0. A lookup offered in that cycle is not accepted and gets no response.
- R7: In the busy cycle err_pulse=1 for exactly one cycle. err_index gives the set, and err_ways gives the failing ways (bit 0 is way 0, bit 1 is way 1).
- R8: At the end of the busy cycle both ways of the set become invalid with clean parity, whichever way failed.
- R9: In cycle t+2 after an error lookup, rsp_valid=1, rsp_hit=0 and rsp_refetch=1.
- R10: A write to the failing set during the busy cycle takes effect after the invalidation, so the written way holds the new entry.
- R11: A lookup and a write in the same cycle: the lookup sees the set contents from before the write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| lk_valid | input | 1 | Lookup request |
| lk_index | input | IDX_W | Set addressed by the lookup |
| lk_tag | input | TAG_W | Tag to compare |
| lk_ready | output | 1 | Lookup can be accepted this cycle |
| rsp_valid | output | 1 | Lookup response present |
| rsp_hit | output | 1 | Response is a hit |
| rsp_way | output | 1 | Way that hit |
| rsp_refetch | output | 1 | Miss caused by a parity error; set cleared |
| wr_en | input | 1 | Tag write enable |
| wr_index | input | IDX_W | Set to write |
| wr_way | input | 1 | Way to write |
| wr_tag | input | TAG_W | Tag to store |
| wr_valid | input | 1 | Valid bit to store |
| wr_par_flip | input | 1 | Store inverted parity (error injection) |
| busy | output | 1 | Set invalidation in progress |
| err_pulse | output | 1 | Parity error detected |
| err_index | output | IDX_W | Set with the error |
| err_ways | output | 2 | Ways that failed parity |

## Verification
The assertions assume two things about the inputs. A lookup counts only when offered with lk_ready high. An error lookup is never followed by a second error lookup before its refetch response. The block itself guarantees the second point, because nothing is accepted while busy is high. The bench keeps lk_valid up during busy cycles on purpose, to show that those requests are dropped. Its random phase draws tags from a small pool and injects parity flips now and then, so it produces hits, misses, duplicate tags and errors. It never forms a two-bit error in one granule, because such an error is undetectable by design.

// File: rtl/icache_tag_check.sv
module icache_tag_check #(
  parameter int SETS  = 16,
  parameter int TAG_W = 30,
  localparam int IDX_W = $clog2(SETS)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             lk_valid,
  input  logic [IDX_W-1:0] lk_index,
  input  logic [TAG_W-1:0] lk_tag,
  output logic             lk_ready,
  output logic             rsp_valid,
  output logic             rsp_hit,
  output logic             rsp_way,
  output logic             rsp_refetch,
  input  logic             wr_en,
  input  logic [IDX_W-1:0] wr_index,
  input  logic             wr_way,
  input  logic [TAG_W-1:0] wr_tag,
  input  logic             wr_valid,
  input  logic             wr_par_flip,
  output logic             busy,
  output logic             err_pulse,
  output logic [IDX_W-1:0] err_index,
  output logic [1:0]       err_ways
);

  logic [SETS-1:0]  vld_q [2];
  logic [SETS-1:0]  par_q [2];
  logic [TAG_W-1:0] tag_q [2][SETS];

  logic             p_v, p_hit, p_way, ref_v;
  logic [IDX_W-1:0] p_idx;
  logic [1:0]       p_err;
  logic [1:0]       bad, match;
  logic             acc;

  always_comb begin
    for (int w = 0; w < 2; w++) begin
      bad[w]   = ^{vld_q[w][lk_index], tag_q[w][lk_index], par_q[w][lk_index]};
      match[w] = vld_q[w][lk_index] && (tag_q[w][lk_index] == lk_tag);
    end
  end

  assign busy        = p_v && (|p_err);
  assign lk_ready    = !busy;
  assign acc         = lk_valid && lk_ready;
  assign rsp_valid   = (p_v && !(|p_err)) || ref_v;
  assign rsp_hit     = p_v && !(|p_err) && p_hit;
  assign rsp_way     = p_way;
  assign rsp_refetch = ref_v;
  assign err_pulse   = busy;
  assign err_index   = p_idx;
  assign err_ways    = p_err;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      p_v   <= 1'b0;
      p_hit <= 1'b0;
      p_way <= 1'b0;
      p_idx <= '0;
      p_err <= '0;
      ref_v <= 1'b0;
    end else begin
      p_v   <= acc;
      ref_v <= busy;
      if (acc) begin
        p_idx <= lk_index;
        p_err <= bad;
        p_hit <= !(|bad) && (|match);
        p_way <= !match[0];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int w = 0; w < 2; w++) begin
        vld_q[w] <= '0;
        par_q[w] <= '0;
        for (int s = 0; s < SETS; s++) tag_q[w][s] <= '0;
      end
    end else begin
      for (int w = 0; w < 2; w++) begin
        if (busy) begin
          vld_q[w][p_idx] <= 1'b0;
          par_q[w][p_idx] <= 1'b0;
          tag_q[w][p_idx] <= '0;
        end
        if (wr_en && (wr_way == w[0])) begin
          vld_q[w][wr_index] <= wr_valid;
          par_q[w][wr_index] <= (^{wr_valid, wr_tag}) ^ wr_par_flip;
          tag_q[w][wr_index] <= wr_tag;
        end
      end
    end
  end

  // R6: the stall lasts a single cycle
  a_r6_busy_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> !busy);

  // R9: stall is followed by a refetch miss
  a_r9_refetch_after_busy: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> (rsp_valid && rsp_refetch && !rsp_hit));

  // R4: every accepted lookup produces a response or a stall next cycle
  a_r4_lookup_answered: assert property (@(posedge clk) disable iff (!rst_n)
    (lk_valid && lk_ready) |=> (rsp_valid || busy));

  // R8: both ways of the failing set are cleared unless rewritten
  a_r8_set_cleared: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !(wr_en && wr_index == p_idx)) |=>
      (!vld_q[0][$past(p_idx)] && !vld_q[1][$past(p_idx)]));

  // R7: an error event always names at least one way
  a_r7_event_names_way: assert property (@(posedge clk) disable iff (!rst_n)
    err_pulse |-> (err_ways != 2'b00));

  // R3: a refetch response is never a hit
  a_r3_refetch_not_hit: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_refetch |-> !rsp_hit);

endmodule

// File: tb/icache_tag_check_tb.sv
module icache_tag_check_tb;
  localparam int SETS = 16;
  localparam int TAG_W = 30;
  localparam int IDX_W = $clog2(SETS);
  localparam time CLK_PERIOD = 10ns;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic lk_valid = 1'b0, wr_en = 1'b0, wr_way = 1'b0, wr_valid = 1'b0, wr_par_flip = 1'b0;
  logic [IDX_W-1:0] lk_index = '0, wr_index = '0;
  logic [TAG_W-1:0] lk_tag = '0, wr_tag = '0;
  logic lk_ready, rsp_valid, rsp_hit, rsp_way, rsp_refetch, busy, err_pulse;
  logic [IDX_W-1:0] err_index;
  logic [1:0] err_ways;

  always #(CLK_PERIOD/2) clk = ~clk;

  icache_tag_check #(.SETS(SETS), .TAG_W(TAG_W)) u_dut (
    .clk(clk), .rst_n(rst_n),
    .lk_valid(lk_valid), .lk_index(lk_index), .lk_tag(lk_tag), .lk_ready(lk_ready),
    .rsp_valid(rsp_valid), .rsp_hit(rsp_hit), .rsp_way(rsp_way), .rsp_refetch(rsp_refetch),
    .wr_en(wr_en), .wr_index(wr_index), .wr_way(wr_way), .wr_tag(wr_tag),
    .wr_valid(wr_valid), .wr_par_flip(wr_par_flip),
    .busy(busy), .err_pulse(err_pulse), .err_index(err_index), .err_ways(err_ways));

  int checks = 0, fails = 0;
  string cur_req = "R1";

  bit mv [2][SETS];
  bit mp [2][SETS];
  logic [TAG_W-1:0] mt [2][SETS];
  bit mpv, mphit, mpway, mref;
  int mpidx;
  bit [1:0] mperr;

  task automatic chk(input bit ok, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d at %0t", cur_req, what, act, exp, $time);
    end
  endtask

  function automatic bit odd(input logic [TAG_W+1:0] v);
    return ($countones(v) % 2) == 1;
  endfunction

  task automatic compare();
    bit eb, ev, eh;
    eb = mpv && (mperr != 0);
    ev = (mpv && mperr == 0) || mref;
    eh = mpv && mperr == 0 && mphit;
    chk(busy == eb, "busy", busy, eb);
    chk(lk_ready == !eb, "lk_ready", lk_ready, !eb);
    chk(rsp_valid == ev, "rsp_valid", rsp_valid, ev);
    if (ev) begin
      chk(rsp_hit == eh, "rsp_hit", rsp_hit, eh);
      chk(rsp_refetch == mref, "rsp_refetch", rsp_refetch, mref);
      if (eh) chk(rsp_way == mpway, "rsp_way", rsp_way, mpway);
    end
    chk(err_pulse == eb, "err_pulse", err_pulse, eb);
    if (eb) begin
      chk(int'(err_index) == mpidx, "err_index", err_index, mpidx);
      chk(err_ways == mperr, "err_ways", err_ways, mperr);
    end
  endtask

  task automatic step(input bit lv, input int li, input logic [TAG_W-1:0] lt,
                      input bit we, input int wi, input bit ww,
                      input logic [TAG_W-1:0] wt, input bit wv, input bit wf);
    bit eb, acc;
    bit [1:0] e, m;
    @(negedge clk);
    compare();
    lk_valid = lv; lk_index = IDX_W'(li); lk_tag = lt;
    wr_en = we; wr_index = IDX_W'(wi); wr_way = ww; wr_tag = wt; wr_valid = wv; wr_par_flip = wf;
    eb = mpv && (mperr != 0);
    acc = lv && !eb;
    for (int w = 0; w < 2; w++) begin
      e[w] = odd({mv[w][li], mt[w][li], mp[w][li]});
      m[w] = mv[w][li] && mt[w][li] == lt;
    end
    if (eb) for (int w = 0; w < 2; w++) begin
      mv[w][mpidx] = 0; mp[w][mpidx] = 0; mt[w][mpidx] = '0;
    end
    if (we) begin
      mv[ww][wi] = wv; mt[ww][wi] = wt; mp[ww][wi] = odd({1'b0, wv, wt}) ^ wf;
    end
    mref = eb;
    mpv = acc;
    if (acc) begin
      mpidx = li; mperr = e; mphit = (e == 0) && (m != 0); mpway = !m[0];
    end
  endtask

  task automatic look(input int i, input logic [TAG_W-1:0] t);
    step(1, i, t, 0, 0, 0, '0, 0, 0);
  endtask
  task automatic wr(input int i, input bit w, input logic [TAG_W-1:0] t, input bit f);
    step(0, 0, '0, 1, i, w, t, 1, f);
  endtask
  task automatic idle();
    step(0, 0, '0, 0, 0, 0, '0, 0, 0);
  endtask

  initial begin
    for (int w = 0; w < 2; w++)
      for (int s = 0; s < SETS; s++) begin mv[w][s] = 0; mp[w][s] = 0; mt[w][s] = '0; end
    mpv = 0; mref = 0; mphit = 0; mpway = 0; mpidx = 0; mperr = 0;
    repeat (3) @(posedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    cur_req = "R1";
    chk(busy == 0 && rsp_valid == 0 && err_pulse == 0, "reset outputs", busy, 0);
    look(0, '0); look(15, 30'h5); look(3, '0); idle();

    cur_req = "R2";
    wr(3, 0, 30'h0AA, 0); wr(3, 1, 30'h155, 0);
    cur_req = "R4";
    look(3, 30'h0AA); look(3, 30'h155); look(3, 30'h0AA); idle();
    cur_req = "R3";
    look(3, 30'h077); look(4, 30'h0AA); idle();

    cur_req = "R11";
    step(1, 5, 30'h3C3, 1, 5, 0, 30'h3C3, 1, 0);
    look(5, 30'h3C3); idle();

    cur_req = "R6";
    wr(7, 0, 30'h111, 0); wr(7, 1, 30'h222, 1);
    look(7, 30'h111); look(7, 30'h111);
    cur_req = "R9"; look(7, 30'h222);
    cur_req = "R8"; look(7, 30'h111); idle(); idle();

    cur_req = "R5";
    step(0, 0, '0, 1, 8, 0, 30'h0F0, 0, 1);
    look(8, 30'h999); idle(); idle(); look(8, 30'h0F0); idle();

    cur_req = "R7";
    wr(2, 0, 30'h123, 1); wr(2, 1, 30'h456, 1);
    look(2, 30'h456); idle(); idle();

    cur_req = "R10";
    wr(9, 0, 30'h0B0, 1); wr(9, 1, 30'h0C0, 0);
    look(9, 30'h0C0);
    step(1, 9, 30'h0D0, 1, 9, 1, 30'h0D0, 1, 0);
    idle(); look(9, 30'h0D0); look(9, 30'h0C0); look(9, 30'h0B0); idle();

    cur_req = "R4";
    for (int n = 0; n < 400; n++) begin
      int r;
      r = $urandom_range(0, 9);
      step(r < 7, $urandom_range(0, 3), 30'($urandom_range(0, 3)),
           r > 4, $urandom_range(0, 3), 1'($urandom_range(0, 1)),
           30'($urandom_range(0, 3)), $urandom_range(0, 5) != 0, $urandom_range(0, 9) == 0);
    end
    idle(); idle(); idle();

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog %s: actual timeout expected completion", cur_req);
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule